// File: doc/BRIEF.md
# Tagged Overwrite-Oldest Result Buffer

This block holds tagged converter results until a host collects them through a register-read path. Each write carries a 12-bit result and a 4-bit channel tag. The buffer keeps up to 15 of these as 16-bit words, with the tag in bits 15:12 and the result in bits 11:0. A read request returns the oldest stored word on the following cycle. When the buffer is full, a new write pushes out the oldest entry, so the newest results are always kept. The block records that loss in a sticky overflow flag.

A read of an empty buffer returns a word whose tag is 4'hF and whose data is zero, and it sets a sticky underflow flag. A separate flag-read strobe clears both flags. The occupancy count is available on a port at all times.

A three-state controller tracks occupancy:
- ST_EMPTY moves to ST_PARTIAL on a write. This is the `fill` transition.
- ST_PARTIAL moves to ST_FULL on a write-only cycle at 14 entries (`top_off`). It moves to ST_EMPTY on a read-only cycle at one entry (`drain`).
- ST_FULL moves to ST_PARTIAL on a read-only cycle (`release`).
- ST_FULL stays where it is on a write, with or without a read (`overwrite`).
- Every other cycle holds the current state.

Top module: `result_fifo`

## Requirements
- R1: After reset, count is 0, both flags are 0, and rd_word is 16'hF000.
- R2: A cycle with wr_valid high and rd_req low, with fewer than 15 entries stored, raises count by one on the next cycle.
- R3: A read request on a non-empty buffer places the oldest entry on rd_word in the cycle after the request, packed as tag in bits 15:12 and data in bits 11:0. Entries come out in write order. rd_word holds its value in cycles with no read request.
- R4: count always equals the number of stored entries (0 to 15). A cycle with both read and write on a partly filled buffer leaves count unchanged.
- R5: A write-only cycle on a full buffer discards the oldest entry and stores the new one. count stays at 15, and later reads return the 15 most recent writes in order.
- R6: A write that discards an entry sets flags bit 0 (overflow). The bit stays set until it is cleared.
- R7: A read request on an empty buffer returns 16'hF000 on rd_word and sets flags bit 1 (underflow). The bit stays set until it is cleared.
- R8: A cycle with both read and write on a full buffer returns the oldest entry and stores the new one. count stays at 15 and the overflow flag is not set.
- R9: A cycle with both read and write on an empty buffer is an underflow read returning 16'hF000. The written entry is stored, leaving count at 1.
- R10: flag_rd clears both flags on the next cycle. An overflow or underflow event in the same cycle as flag_rd leaves its flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write strobe for one result |
| wr_tag | input | 4 | Channel tag of the result |
| wr_data | input | 12 | Converter result |
| rd_req | input | 1 | Read request for the oldest entry |
| rd_word | output | 16 | Last word read: tag in 15:12, data in 11:0 |
| flag_rd | input | 1 | Flag-read strobe; clears the sticky flags |
| flags | output | 2 | Bit 0 overflow, bit 1 underflow |
| count | output | 4 | Number of stored entries |

## Verification
The bench builds the block with its default parameters: depth 15, 12 data bits and 4 tag bits. Because 15 is not a power of two, the pointers must wrap explicitly from 14 back to 0, and the bench drives enough traffic to cross that wrap several times. With a 4-bit count, the full state sits at the count's largest value, 15, so the bench also covers an off-by-one at that point. The bench compares every cycle against a reference queue, including simultaneous read and write at both the empty and the full boundary.

// File: rtl/rfifo_pkg.sv
package rfifo_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_PARTIAL = 2'd1,
        ST_FULL    = 2'd2
    } fifo_state_e;

    localparam int FLAG_OVF = 0;
    localparam int FLAG_UNF = 1;
    localparam int FLAG_W   = 2;

endpackage

// File: rtl/rfifo_store.sv
module rfifo_store #(
    parameter int DEPTH  = 15,
    parameter int WORD_W = 16,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [WORD_W-1:0] wr_word,
    input  logic [AW-1:0]     rd_addr,
    output logic [WORD_W-1:0] rd_data
);

    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_word;
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/rfifo_ctrl.sv
module rfifo_ctrl
    import rfifo_pkg::*;
#(
    parameter int DEPTH = 15,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_valid,
    input  logic          rd_req,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] rd_addr,
    output logic          pop,
    output logic          ovf_evt,
    output logic          unf_evt,
    output logic [CW-1:0] count
);

    fifo_state_e   state_q, state_d;
    logic [AW-1:0] head_q, tail_q;
    logic [CW-1:0] count_q, count_d;
    logic          drop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // named transitions: fill, top_off, drain, release, overwrite
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (wr_valid) begin
                    state_d = (DEPTH == 1) ? ST_FULL : ST_PARTIAL;
                end
            end
            ST_PARTIAL: begin
                if (wr_valid && !rd_req && count_q == CW'(DEPTH - 1)) begin
                    state_d = ST_FULL;
                end else if (rd_req && !wr_valid && count_q == CW'(1)) begin
                    state_d = ST_EMPTY;
                end
            end
            ST_FULL: begin
                if (rd_req && !wr_valid) begin
                    state_d = (DEPTH == 1) ? ST_EMPTY : ST_PARTIAL;
                end
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    // per-state outputs
    always_comb begin
        pop     = 1'b0;
        drop    = 1'b0;
        unf_evt = 1'b0;
        unique case (state_q)
            ST_EMPTY: begin
                unf_evt = rd_req;
            end
            ST_PARTIAL: begin
                pop = rd_req;
            end
            ST_FULL: begin
                pop  = rd_req;
                drop = wr_valid && !rd_req;
            end
            default: begin
                pop = 1'b0;
            end
        endcase
        ovf_evt = drop;
    end

    always_comb begin
        unique case ({wr_valid, pop || drop})
            2'b10:   count_d = count_q + 1'b1;
            2'b01:   count_d = count_q - 1'b1;
            default: count_d = count_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
        end else begin
            count_q <= count_d;
            if (wr_valid) begin
                tail_q <= bump(tail_q);
            end
            if (pop || drop) begin
                head_q <= bump(head_q);
            end
        end
    end

    assign wr_en   = wr_valid;
    assign wr_addr = tail_q;
    assign rd_addr = head_q;
    assign count   = count_q;

    // R4
    count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CW'(DEPTH));

    // R4
    state_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_EMPTY) == (count_q == '0)) &&
        ((state_q == ST_FULL) == (count_q == CW'(DEPTH))));

endmodule

// File: rtl/rfifo_flags.sv
module rfifo_flags
    import rfifo_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ovf_evt,
    input  logic              unf_evt,
    input  logic              clr,
    output logic [FLAG_W-1:0] flags
);

    logic [FLAG_W-1:0] evt;

    assign evt[FLAG_OVF] = ovf_evt;
    assign evt[FLAG_UNF] = unf_evt;

    for (genvar g = 0; g < FLAG_W; g++) begin : g_flag
        logic bit_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bit_q <= 1'b0;
            end else if (evt[g]) begin
                bit_q <= 1'b1;
            end else if (clr) begin
                bit_q <= 1'b0;
            end
        end
        assign flags[g] = bit_q;
    end

endmodule

// File: rtl/result_fifo.sv
module result_fifo
    import rfifo_pkg::*;
#(
    parameter int DEPTH  = 15,
    parameter int DATA_W = 12,
    parameter int TAG_W  = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_valid,
    input  logic [TAG_W-1:0]           wr_tag,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic                       rd_req,
    output logic [TAG_W+DATA_W-1:0]    rd_word,
    input  logic                       flag_rd,
    output logic [FLAG_W-1:0]          flags,
    output logic [$clog2(DEPTH+1)-1:0] count
);

    localparam int WORD_W = TAG_W + DATA_W;
    localparam int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW     = $clog2(DEPTH + 1);
    localparam logic [WORD_W-1:0] EMPTY_WORD = {{TAG_W{1'b1}}, {DATA_W{1'b0}}};

    logic          wr_en, pop, ovf_evt, unf_evt;
    logic [AW-1:0] wr_addr, rd_addr;
    logic [WORD_W-1:0] head_word;
    logic [WORD_W-1:0] rd_word_q;

    rfifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (wr_valid),
        .rd_req   (rd_req),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .rd_addr  (rd_addr),
        .pop      (pop),
        .ovf_evt  (ovf_evt),
        .unf_evt  (unf_evt),
        .count    (count)
    );

    rfifo_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_word ({wr_tag, wr_data}),
        .rd_addr (rd_addr),
        .rd_data (head_word)
    );

    rfifo_flags u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .ovf_evt (ovf_evt),
        .unf_evt (unf_evt),
        .clr     (flag_rd),
        .flags   (flags)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_word_q <= EMPTY_WORD;
        end else if (rd_req) begin
            rd_word_q <= pop ? head_word : EMPTY_WORD;
        end
    end

    assign rd_word = rd_word_q;

    // R2
    count_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !rd_req && count < CW'(DEPTH) |=> count == $past(count) + 1'b1);

    // R3
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> $stable(rd_word));

    // R6
    overflow_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !rd_req && count == CW'(DEPTH) |=> flags[FLAG_OVF] && count == CW'(DEPTH));

    // R7
    underflow_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && count == '0 |=> rd_word == EMPTY_WORD && flags[FLAG_UNF]);

    // R8
    full_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && wr_valid && count == CW'(DEPTH) && !flags[FLAG_OVF]
        |=> count == CW'(DEPTH) && !flags[FLAG_OVF]);

    // R10
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_rd && !wr_valid && !rd_req |=> flags == '0);

endmodule

// File: tb/test_result_fifo.sv
module test_result_fifo;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [3:0]  wr_tag = '0;
    logic [11:0] wr_data = '0;
    logic        rd_req = 1'b0;
    logic        flag_rd = 1'b0;
    logic [15:0] rd_word;
    logic [1:0]  flags;
    logic [3:0]  count;

    int compared = 0;
    int mismatched = 0;

    logic [15:0] mq[$];
    logic [15:0] exp_word = 16'hF000;
    logic        exp_ovf = 1'b0;
    logic        exp_unf = 1'b0;

    always #5 clk = ~clk;

    result_fifo i_result_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (wr_valid),
        .wr_tag   (wr_tag),
        .wr_data  (wr_data),
        .rd_req   (rd_req),
        .rd_word  (rd_word),
        .flag_rd  (flag_rd),
        .flags    (flags),
        .count    (count)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // one clock of stimulus, reference model update, then checks at the negedge
    task automatic step(input logic wv, input logic [3:0] tg, input logic [11:0] dt,
                        input logic rd, input logic frd, input string req);
        logic ov_e, un_e;
        ov_e = 1'b0;
        un_e = 1'b0;
        wr_valid = wv; wr_tag = tg; wr_data = dt; rd_req = rd; flag_rd = frd;
        if (rd) begin
            if (mq.size() == 0) begin
                exp_word = 16'hF000;
                un_e = 1'b1;
            end else begin
                exp_word = mq.pop_front();
            end
        end
        if (wv) begin
            if (mq.size() == 15) begin
                void'(mq.pop_front());
                ov_e = 1'b1;
            end
            mq.push_back({tg, dt});
        end
        exp_ovf = (frd ? 1'b0 : exp_ovf) | ov_e;
        exp_unf = (frd ? 1'b0 : exp_unf) | un_e;
        @(negedge clk);
        wr_valid = 1'b0; rd_req = 1'b0; flag_rd = 1'b0;
        chk(req, "count", 32'(count), 32'(mq.size()));
        chk(req, "flags", 32'(flags), 32'({exp_unf, exp_ovf}));
        chk(req, "rd_word", 32'(rd_word), 32'(exp_word));
    endtask

    task automatic t_reset();
        chk("R1", "count", 32'(count), 32'd0);
        chk("R1", "flags", 32'(flags), 32'd0);
        chk("R1", "rd_word", 32'(rd_word), 32'hF000);
    endtask

    task automatic t_fill_drain();
        for (int i = 0; i < 5; i++) step(1'b1, 4'(i + 2), 12'(12'h100 + i), 1'b0, 1'b0, "R2");
        chk("R4", "count after 5", 32'(count), 32'd5);
        for (int i = 0; i < 5; i++) step(1'b0, 4'd0, 12'd0, 1'b1, 1'b0, "R3");
        chk("R3", "last word", 32'(rd_word), 32'h6104);
        step(1'b0, 4'd0, 12'd0, 1'b0, 1'b0, "R3");
        chk("R3", "held word", 32'(rd_word), 32'h6104);
    endtask

    task automatic t_underflow();
        step(1'b0, 4'd0, 12'd0, 1'b1, 1'b0, "R7");
        chk("R7", "underflow flag", 32'(flags[1]), 32'd1);
        step(1'b0, 4'd0, 12'd0, 1'b0, 1'b0, "R7");
        step(1'b0, 4'd0, 12'd0, 1'b0, 1'b1, "R10");
        chk("R10", "flags cleared", 32'(flags), 32'd0);
    endtask

    task automatic t_overflow();
        for (int i = 0; i < 15; i++) step(1'b1, 4'(i % 15), 12'(12'h200 + i), 1'b0, 1'b0, "R2");
        chk("R5", "count full", 32'(count), 32'd15);
        chk("R6", "no overflow yet", 32'(flags[0]), 32'd0);
        for (int i = 15; i < 18; i++) step(1'b1, 4'(i % 15), 12'(12'h200 + i), 1'b0, 1'b0, "R6");
        chk("R5", "count stays full", 32'(count), 32'd15);
        step(1'b0, 4'd0, 12'd0, 1'b1, 1'b0, "R5");
        chk("R5", "oldest kept", 32'(rd_word), 32'h3203);
        for (int i = 0; i < 14; i++) step(1'b0, 4'd0, 12'd0, 1'b1, 1'b0, "R5");
        chk("R6", "overflow sticky", 32'(flags[0]), 32'd1);
        step(1'b0, 4'd0, 12'd0, 1'b0, 1'b1, "R10");
    endtask

    task automatic t_full_both();
        for (int i = 0; i < 20; i++) step(1'b1, 4'(i % 15), 12'(12'h300 + i), 1'b0, 1'b0, "R5");
        step(1'b0, 4'd0, 12'd0, 1'b0, 1'b1, "R10");
        step(1'b1, 4'd9, 12'hABC, 1'b1, 1'b0, "R8");
        chk("R8", "no overflow", 32'(flags[0]), 32'd0);
        chk("R8", "oldest returned", 32'(rd_word), 32'h5305);
        step(1'b1, 4'd8, 12'h123, 1'b1, 1'b0, "R8");
        for (int i = 0; i < 15; i++) step(1'b0, 4'd0, 12'd0, 1'b1, 1'b0, "R3");
        chk("R8", "last is newest", 32'(rd_word), 32'h8123);
    endtask

    task automatic t_empty_both();
        step(1'b0, 4'd0, 12'd0, 1'b0, 1'b1, "R10");
        step(1'b1, 4'd7, 12'h777, 1'b1, 1'b0, "R9");
        chk("R9", "count one", 32'(count), 32'd1);
        chk("R9", "underflow word", 32'(rd_word), 32'hF000);
        step(1'b0, 4'd0, 12'd0, 1'b1, 1'b0, "R9");
        chk("R9", "stored entry", 32'(rd_word), 32'h7777);
    endtask

    task automatic t_mid_both();
        for (int i = 0; i < 3; i++) step(1'b1, 4'(i + 1), 12'(12'h400 + i), 1'b0, 1'b0, "R2");
        for (int i = 0; i < 4; i++) step(1'b1, 4'(i + 10), 12'(12'h410 + i), 1'b1, 1'b0, "R4");
        chk("R4", "count unchanged", 32'(count), 32'd3);
        for (int i = 0; i < 3; i++) step(1'b0, 4'd0, 12'd0, 1'b1, 1'b0, "R3");
    endtask

    task automatic t_set_wins();
        step(1'b0, 4'd0, 12'd0, 1'b1, 1'b1, "R10");
        chk("R10", "underflow wins clear", 32'(flags[1]), 32'd1);
        for (int i = 0; i < 15; i++) step(1'b1, 4'(i), 12'(12'h500 + i), 1'b0, 1'b0, "R2");
        step(1'b1, 4'd3, 12'h5FF, 1'b0, 1'b1, "R10");
        chk("R10", "overflow wins clear", 32'(flags), 32'd1);
        for (int i = 0; i < 15; i++) step(1'b0, 4'd0, 12'd0, 1'b1, 1'b0, "R3");
        step(1'b0, 4'd0, 12'd0, 1'b0, 1'b1, "R10");
    endtask

    initial begin
        #200000;
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fill_drain();
        t_underflow();
        t_overflow();
        t_full_both();
        t_empty_both();
        t_mid_both();
        t_set_wins();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule